// File: doc/BRIEF.md
# Latched-Address Byte-Lane Static Memory

This block is a word-organised static memory with a front end of input latches. The word address and an active-low select share one latch enable. The write data has a second latch enable of its own. While an enable is high its latch follows its inputs. While it is low the latch keeps what it captured at the last clock edge where the enable was high. With both enables tied high the block behaves as a plain static memory with no latching.

The data word is split into lanes of nine bits, two by default, giving 18-bit words. Each lane has its own active-low write strobe, so a lane can be written alone or together with the others. The shared bidirectional data bus is modelled as a write-data input, a read-data output and a drive flag. The flag is low whenever the output must float, and the read data is then forced to zero.

Because the block is synchronous, the latch contents, the writes and the read pipeline all act on the clock edge. The memory depth is 2**ADDR_W words. A full-size instance uses ADDR_W = 16; the default is smaller.

Top module: `lsram_top`

## Requirements
- R1: While `addr_le` is high at a clock edge, that edge uses the current `addr_i` and `sel_n` directly. A high `sel_n` then stops `drive_o` from rising after that edge.
- R2: While `addr_le` is low, the address and select hold the values captured at the last edge where `addr_le` was high, whatever `addr_i` and `sel_n` do.
- R3: While `data_le` is high, writes use the current `wdata_i`. While it is low, writes use the data captured at the last edge where `data_le` was high.
- R4: `wr_n[0]` low writes bits 8:0 and `wr_n[1]` low writes bits 17:9 of the addressed word. Lanes whose strobe is high keep their contents.
- R5: With both latch enables held high, a word written at an address is returned by a later read of that address.
- R6: If the effective select is high (deselected), strobes change no memory content and `drive_o` is low after the edge.
- R7: At an edge where the block is selected, `oe_n` is low and all strobes are high, the next cycle has `drive_o` = 1 and `rdata_o` equal to the stored word.
- R8: At an edge where `oe_n` is high or any strobe is low, `drive_o` is 0 after that edge. Whenever `drive_o` is 0, `rdata_o` is all zeros.
- R9: A synchronous reset (`rst` high) clears `drive_o`, leaves the address latch holding address 0 in the deselected state, and clears the data latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_le | input | 1 | Address/select latch enable, high = transparent |
| addr_i | input | ADDR_W | Word address |
| sel_n | input | 1 | Chip select, active low |
| data_le | input | 1 | Write-data latch enable, high = transparent |
| wdata_i | input | LANES*LANE_W | Write data (inbound side of the shared bus) |
| wr_n | input | LANES | Per-lane write strobes, active low, bit 0 = lowest lane |
| oe_n | input | 1 | Output enable, active low |
| rdata_o | output | LANES*LANE_W | Read data, zero while not driven |
| drive_o | output | 1 | High while the shared bus is driven by the block |

## Verification
A write strobe and an output-enable request can fall on the same edge. The bench provokes this by pulling one strobe low while `oe_n` is low, and judges that `drive_o` stays low while only the strobed lane changes. A held latch and a write can also fall on the same edge. The bench writes while `addr_i` and `wdata_i` are wandering with their enables low. A cycle-accurate reference model then judges which address and data actually landed, by reading back both the held address and the wandered one.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/lsram_latch.sv
// Clock-sampled transparent latch: follows d while le is high,
// otherwise presents the value captured at the last enabled edge.
module lsram_latch #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)     hold_q <= RST_VAL;
    else if (le) hold_q <= d;
  end

  assign q = le ? d : hold_q;
endmodule

// File: rtl/lsram_lanes.sv
// One inferable RAM per lane, written independently, read registered.
module lsram_lanes #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned DW    = LANE_W * LANES
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      rd_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/lsram_out.sv
// Registered bus-drive flag; read data forced to zero when floating.
module lsram_out
  import lsram_pkg::*;
#(
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  acc_e          acc,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= (acc == ACC_READ);
  end

  assign drive_o = drive_q;
  assign rdata_o = drive_q ? rd_word : '0;
endmodule

// File: rtl/lsram_top.sv
module lsram_top
  import lsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DW    = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_le,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_n,
  input  logic              data_le,
  input  logic [DW-1:0]     wdata_i,
  input  logic [LANES-1:0]  wr_n,
  input  logic              oe_n,
  output logic [DW-1:0]     rdata_o,
  output logic              drive_o
);
  localparam logic [ADDR_W:0] AC_RST = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0]     ac_lat;
  logic                lat_sel_n;
  logic [ADDR_W-1:0]   lat_addr;
  logic [DW-1:0]       lat_data;
  logic [DW-1:0]       rd_word;
  logic [LANES-1:0]    lane_we;
  acc_e                acc;

  lsram_latch #(.W(ADDR_W + 1), .RST_VAL(AC_RST)) u_alat (
    .clk(clk), .rst(rst), .le(addr_le), .d({sel_n, addr_i}), .q(ac_lat)
  );
  assign lat_sel_n = ac_lat[ADDR_W];
  assign lat_addr  = ac_lat[ADDR_W-1:0];

  lsram_latch #(.W(DW), .RST_VAL('0)) u_dlat (
    .clk(clk), .rst(rst), .le(data_le), .d(wdata_i), .q(lat_data)
  );

  always_comb begin
    if (lat_sel_n)       acc = ACC_IDLE;
    else if (wr_n != '1) acc = ACC_WRITE;
    else if (!oe_n)      acc = ACC_READ;
    else                 acc = ACC_IDLE;
  end

  assign lane_we = (acc == ACC_WRITE) ? ~wr_n : '0;

  lsram_lanes #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk(clk), .addr(lat_addr), .we(lane_we), .wdata(lat_data), .rdata(rd_word)
  );

  lsram_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .acc(acc), .rd_word(rd_word),
    .rdata_o(rdata_o), .drive_o(drive_o)
  );

  // R1: a transparent deselect prevents driving
  a_r1_sel_through: assert property (@(posedge clk) disable iff (rst)
    (addr_le && sel_n) |=> !drive_o);
  // R2: held address stays put across consecutive closed edges
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!addr_le ##1 !addr_le) |-> $stable(ac_lat));
  // R3: held write data stays put
  a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
    (!data_le ##1 !data_le) |-> $stable(lat_data));
  // R6: deselected means no lane write
  a_r6_no_write_desel: assert property (@(posedge clk) disable iff (rst)
    lat_sel_n |-> (lane_we == '0));
  // R8: strobe or closed output enable blocks the driver
  a_r8_no_drive: assert property (@(posedge clk) disable iff (rst)
    ((wr_n != '1) || oe_n) |=> !drive_o);
  // R8: floating bus reads as zero
  a_r8_zero_float: assert property (@(posedge clk) disable iff (rst)
    !drive_o |-> (rdata_o == '0));
  // R9: reset leaves the driver off
  a_r9_reset_off: assert property (@(posedge clk)
    $past(rst) |-> !drive_o);
endmodule

// File: tb/tb_lsram_top.sv
module tb_lsram_top;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int LW    = 9;
  localparam int NL    = 2;
  localparam int DW    = LW * NL;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          addr_le, sel_n, data_le, oe_n;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic [NL-1:0] wr_n;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  always #(CLK_P/2) clk = ~clk;

  lsram_top #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) dut (
    .clk(clk), .rst(rst), .addr_le(addr_le), .addr_i(addr_i), .sel_n(sel_n),
    .data_le(data_le), .wdata_i(wdata_i), .wr_n(wr_n), .oe_n(oe_n),
    .rdata_o(rdata_o), .drive_o(drive_o)
  );

  // behavioural reference model
  logic [DW-1:0] shadow [DEPTH];
  int            m_addr;
  logic          m_sel_n;
  logic [DW-1:0] m_data;
  logic          exp_en;
  logic [DW-1:0] exp_q;
  int            checks = 0;
  int            fails  = 0;
  string         tag    = "R9";
  bit            done   = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_sel_n = 1'b1; m_data = '0; exp_en = 1'b0; exp_q = '0;
    end else begin
      int ea; logic es; logic [DW-1:0] ed;
      ea = addr_le ? int'(addr_i) : m_addr;
      es = addr_le ? sel_n : m_sel_n;
      ed = data_le ? wdata_i : m_data;
      exp_en = !es && (wr_n == '1) && !oe_n;
      exp_q  = exp_en ? shadow[ea] : '0;
      if (!es)
        for (int l = 0; l < NL; l++)
          if (!wr_n[l]) shadow[ea][l*LW +: LW] = ed[l*LW +: LW];
      if (addr_le) begin m_addr = int'(addr_i); m_sel_n = sel_n; end
      if (data_le) m_data = wdata_i;
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      checks++;
      if (drive_o !== exp_en || rdata_o !== exp_q) begin
        fails++;
        $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                 tag, drive_o, rdata_o, exp_en, exp_q);
      end
    end
  end

  task automatic put(input int a, input logic ale, input logic sn,
                     input logic [DW-1:0] d, input logic dle,
                     input logic [NL-1:0] w, input logic oe);
    @(negedge clk);
    addr_i = AW'(a); addr_le = ale; sel_n = sn;
    wdata_i = d; data_le = dle; wr_n = w; oe_n = oe;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 2897) ^ 18'h2A5C3;
  endfunction

  initial begin
    rst = 1'b1; addr_le = 1'b0; addr_i = '0; sel_n = 1'b1;
    data_le = 1'b0; wdata_i = '0; wr_n = '1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: after reset the held select is deselected, so no drive
    tag = "R9";
    rst = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (drive_o !== 1'b0 || rdata_o !== '0) begin
      fails++;
      $display("FAIL R9: drive=%b data=%h expected drive=0 data=0", drive_o, rdata_o);
    end
    // R5: transparent fill and read-back
    tag = "R5";
    for (int i = 0; i < DEPTH; i++) put(i, 1, 0, pat(i), 1, 2'b00, 1);
    for (int i = 0; i < DEPTH; i++) put(i, 1, 0, '0, 1, 2'b11, 0);
    // R4: single-lane and dual-lane writes
    tag = "R4";
    put(3, 1, 0, 18'h15A5A, 1, 2'b10, 1);
    put(4, 1, 0, 18'h2C3C3, 1, 2'b01, 1);
    put(5, 1, 0, 18'h0F0F0, 1, 2'b00, 1);
    for (int i = 3; i < 6; i++) put(i, 1, 0, '0, 1, 2'b11, 0);
    // R1: transparent deselect blocks a read
    tag = "R1";
    put(6, 1, 1, '0, 1, 2'b11, 0);
    put(6, 1, 0, '0, 1, 2'b11, 0);
    // R2: held address while addr_i wanders, read and write
    tag = "R2";
    put(10, 1, 0, '0, 1, 2'b11, 0);
    put(20, 0, 1, '0, 1, 2'b11, 0);
    put(21, 0, 1, '0, 1, 2'b11, 0);
    put(33, 0, 1, 18'h2BEEF, 1, 2'b00, 1);
    put(10, 1, 0, '0, 1, 2'b11, 0);
    put(33, 1, 0, '0, 1, 2'b11, 0);
    // R3: held write data
    tag = "R3";
    put(12, 1, 0, 18'h1C3C3, 1, 2'b11, 1);
    put(12, 1, 0, 18'h00011, 0, 2'b00, 1);
    put(12, 1, 0, 18'h3FFFF, 0, 2'b11, 0);
    // R6: deselected writes ignored, transparent and held
    tag = "R6";
    put(7, 1, 1, 18'h3FFFF, 1, 2'b00, 0);
    put(7, 1, 1, '0, 1, 2'b11, 1);
    put(7, 0, 0, 18'h3FFFF, 1, 2'b00, 0);
    put(7, 1, 0, '0, 1, 2'b11, 0);
    // R8: closed output enable and strobe with open output enable
    tag = "R8";
    put(8, 1, 0, '0, 1, 2'b11, 1);
    put(8, 1, 0, 18'h12345, 1, 2'b10, 0);
    put(8, 1, 0, '0, 1, 2'b11, 0);
    // R7: back-to-back reads
    tag = "R7";
    for (int i = 0; i < 16; i++) put(i, 1, 0, '0, 1, 2'b11, 0);
    put(0, 1, 0, '0, 1, 2'b11, 1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule